// File: doc/BRIEF.md
# Atomic Channel Mask Update Unit

This unit sits beside a 32-bit interrupt mask that covers sixteen DMA channels. Each channel owns two mask bits, one for the source side and one for the destination side. Software never edits the mask word directly. Instead it writes a single 32-bit update word that carries four independent update slots. Each slot names a channel, picks the source or destination bit, supplies the new value and carries an arm bit.

Every armed slot rewrites only the one mask bit it targets. All other bits keep their value, so software needs no read-modify-write sequence. Once a slot has acted, its arm bit clears by itself. The unit offers two read paths: a readback of the update word and a live view of the mask.

Top module: `chan_mask_update`

## Requirements
- R1: After a synchronous reset, both the update word readback and the mask read port are all zeros.
- R2: Slot s occupies bits [8s+7:8s] of the update word. Within a slot, bits [7:3] hold the channel code, bit 2 the destination select, bit 1 the new value and bit 0 the arm bit.
- R3: Suppose the write edge is edge 0. An armed slot with a valid channel code (0 to 15) loads its new value into mask bit 2*channel+select at edge 1. A value of 1 masks the interrupt and 0 unmasks it. The mask read port shows no change before edge 1.
- R4: A select bit of 1 targets the odd (destination) bit of the channel pair. A select bit of 0 targets the even (source) bit.
- R5: A slot whose channel code has its top bit set is reserved. It changes no mask bit, and its arm bit still clears.
- R6: One edge after a write, the update word readback returns the written channel, select and value fields with every arm bit at 0. These fields hold until the next write.
- R7: Mask bits that no armed slot targets keep their value. A write with all four arm bits at 0 leaves the whole mask unchanged.
- R8: All armed slots of one write apply at the same edge. When two or more slots target the same bit, the highest-numbered slot sets its value.
- R9: The mask read port always presents the current 32-bit mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_wr | input | 1 | Write strobe for the update word |
| upd_wdata | input | 32 | Update word: four slots |
| upd_rdata | output | 32 | Readback of the update word |
| mask_rdata | output | 32 | Current mask register |

## Verification
Each write is launched at a falling edge and captured at the next rising edge. The mask then changes at the rising edge after that. The bench therefore samples the mask and the readback at the second falling edge after the strobe. A directed probe also samples the mask one falling edge after capture, to confirm it has not yet moved. Vector entries build on the mask left by the previous entry, so the R7 hold behaviour is checked against accumulated state, not just against zeros.

// File: rtl/mask_upd_pkg.sv
package mask_upd_pkg;
    localparam int CH_W   = 5;
    localparam int SLOT_W = CH_W + 3;

    typedef struct packed {
        logic [CH_W-1:0] chan;
        logic            dst;
        logic            val;
        logic            arm;
    } slot_t;

    function automatic logic [31:0] arm_bits(input int n_slots);
        logic [31:0] m;
        m = '0;
        for (int s = 0; s < n_slots; s++) m[s*SLOT_W] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/upd_reg.sv
module upd_reg
    import mask_upd_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    localparam int WORD_W = NUM_SLOTS * SLOT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] q
);
    localparam logic [WORD_W-1:0] ARM_M = WORD_W'(arm_bits(NUM_SLOTS));

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (wr) q <= wdata;
        else         q <= q & ~ARM_M;
    end

    p_arm_clear_r6: assert property (@(posedge clk) disable iff (rst)
        !wr |=> ((q & ARM_M) == '0));
    p_fields_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !wr |=> ((q & ~ARM_M) == ($past(q) & ~ARM_M)));
endmodule

// File: rtl/slot_dec.sv
module slot_dec
    import mask_upd_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int MASK_W = 2 * NUM_CH
) (
    input  slot_t             slot,
    output logic [MASK_W-1:0] hit
);
    logic              valid;
    logic [CH_W:0]     idx;

    always_comb begin
        valid = int'(slot.chan) < NUM_CH;
        idx   = {slot.chan, slot.dst};
        hit   = (slot.arm && valid) ? (MASK_W'(1) << idx) : '0;
    end
endmodule

// File: rtl/mask_bank.sv
module mask_bank
    import mask_upd_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int NUM_CH    = 16,
    localparam int MASK_W = 2 * NUM_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_t             slots [NUM_SLOTS],
    output logic [MASK_W-1:0] mask_q
);
    logic [MASK_W-1:0] hit [NUM_SLOTS];
    logic [MASK_W-1:0] any_hit;
    logic [MASK_W-1:0] nxt;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_dec
        slot_dec #(.NUM_CH(NUM_CH)) u_dec (.slot(slots[s]), .hit(hit[s]));

        p_onehot_r3: assert property (@(posedge clk) disable iff (rst)
            $onehot0(hit[s]));
        p_reserved_r5: assert property (@(posedge clk) disable iff (rst)
            (slots[s].arm && slots[s].chan[CH_W-1]) |-> (hit[s] == '0));
    end

    // Later slots overwrite earlier ones: highest index has priority (R8)
    always_comb begin
        nxt     = mask_q;
        any_hit = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            any_hit = any_hit | hit[s];
            for (int b = 0; b < MASK_W; b++)
                if (hit[s][b]) nxt[b] = slots[s].val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= nxt;
    end

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (any_hit == '0) |=> $stable(mask_q));
    p_top_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (hit[NUM_SLOTS-1] != '0) |=>
        ((mask_q & $past(hit[NUM_SLOTS-1])) ==
         ($past(slots[NUM_SLOTS-1].val) ? $past(hit[NUM_SLOTS-1]) : '0)));
endmodule

// File: rtl/chan_mask_update.sv
module chan_mask_update
    import mask_upd_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int NUM_CH    = 16,
    localparam int WORD_W = NUM_SLOTS * SLOT_W,
    localparam int MASK_W = 2 * NUM_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_wr,
    input  logic [WORD_W-1:0] upd_wdata,
    output logic [WORD_W-1:0] upd_rdata,
    output logic [MASK_W-1:0] mask_rdata
);
    logic [WORD_W-1:0] upd_q;
    slot_t             slots [NUM_SLOTS];

    upd_reg #(.NUM_SLOTS(NUM_SLOTS)) u_upd (
        .clk(clk), .rst(rst), .wr(upd_wr), .wdata(upd_wdata), .q(upd_q)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign slots[s] = slot_t'(upd_q[s*SLOT_W +: SLOT_W]);
    end

    mask_bank #(.NUM_SLOTS(NUM_SLOTS), .NUM_CH(NUM_CH)) u_bank (
        .clk(clk), .rst(rst), .slots(slots), .mask_q(mask_rdata)
    );

    assign upd_rdata = upd_q;

    p_no_arm_no_change_r7: assert property (@(posedge clk) disable iff (rst)
        ((upd_q & WORD_W'(arm_bits(NUM_SLOTS))) == '0) |=> $stable(mask_rdata));
endmodule

// File: tb/chan_mask_update_bench.sv
module chan_mask_update_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        upd_wr = 1'b0;
    logic [31:0] upd_wdata = '0;
    logic [31:0] upd_rdata, mask_rdata;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    localparam logic [31:0] ARMS = 32'h0101_0101;

    // {update word, expected mask after it}; entries accumulate
    localparam logic [63:0] VEC [7] = '{
        {32'h0000_001B, 32'h0000_0040},  // R3: ch3 src mask -> bit6
        {32'h0000_7F03, 32'h8000_0041},  // R4: ch15 dst -> bit31, ch0 src -> bit0
        {32'h1987_0000, 32'h8000_0001},  // R5: ch16 reserved ignored; ch3 unmask
        {32'hFEFE_FEFE, 32'h8000_0001},  // R7: no arm bits
        {32'h2D00_2F2F, 32'h8000_0001},  // R8: slot3 unmask wins on bit11
        {32'h2F00_002D, 32'h8000_0801},  // R8: slot3 mask wins on bit11
        {32'h017D_170B, 32'h0000_0824}   // R8: four slots at once
    };

    chan_mask_update u_chan_mask_update (
        .clk(clk), .rst(rst), .upd_wr(upd_wr), .upd_wdata(upd_wdata),
        .upd_rdata(upd_rdata), .mask_rdata(mask_rdata)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [31:0] w);
        @(negedge clk);
        upd_wr = 1'b1;
        upd_wdata = w;
        @(negedge clk);
        upd_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 upd", upd_rdata, 32'h0);
        check("R1 mask", mask_rdata, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < 7; i++) begin
            write_word(VEC[i][63:32]);
            @(negedge clk);
            check("R9 mask", mask_rdata, VEC[i][31:0]);
            check("R6 readback", upd_rdata, VEC[i][63:32] & ~ARMS);
        end

        // R3 timing: no mask change before the apply edge
        write_word(32'h0000_0003);           // ch0 src mask -> bit0
        check("R3 early", mask_rdata, 32'h0000_0824);
        @(negedge clk);
        check("R3 applied", mask_rdata, 32'h0000_0825);
        // R6: fields hold through idle cycles
        repeat (3) @(negedge clk);
        check("R6 hold", upd_rdata, 32'h0000_0002);
        check("R7 idle", mask_rdata, 32'h0000_0825);

        // R5: reserved code 31 dst mask in slot0 only
        write_word(32'h0000_00FF);
        @(negedge clk);
        check("R5 mask", mask_rdata, 32'h0000_0825);
        check("R5 arm clear", upd_rdata, 32'h0000_00FE);

        // R2: slot2 ch7 dst mask -> bit15
        write_word(32'h003F_0000);
        @(negedge clk);
        check("R2 slot2", mask_rdata, 32'h0000_8825);

        // R1: reset again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 re-reset mask", mask_rdata, 32'h0);
        check("R1 re-reset upd", upd_rdata, 32'h0);
        done = 1'b1;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
    end

    initial begin
        wait (done || n_fail > 0 && $time > 20000);
        #1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule